// File: doc/BRIEF.md
# Smart Card T=0 Character Transmitter

This block sends host bytes to a smart card over the single bidirectional I/O line, following the character-level rules of the T=0 protocol. The host always writes plain bytes in direct convention. The block codes each byte in the convention chosen at answer-to-reset, appends the parity bit and shifts the character out at one bit per elementary time unit (ETU). It drives the line through an open-drain style output: it either pulls the line low or leaves it released.

After the parity bit the block releases the line and reads the card's level one ETU into the guard time. A low level there is the card asking for a repeat. The block then sends the same byte again after a longer spacing, up to a host-set number of times, and raises a sticky error flag if the card keeps refusing.

A one-character holding buffer lets the host queue the next byte while the current one is on the line. A flag written with a byte marks it as the last of a command. When that byte finishes and nothing is queued, the block signals that the line belongs to the receiver.

Top module: `t0_char_tx`

## Requirements
- R1: While reset is held and right after it, `io_pull_low`, `empty_irq`, `tx_err` and `rx_mode` are 0 and `buf_empty` is 1.
- R2: With `conv_inv`=0, a character is a low start bit, then data bits least significant first with line high for 1, then a parity bit that is high when the byte has an odd number of ones. Each bit lasts `ETU_CLKS` clocks. When the block is idle, the start bit begins on the second clock after the clock in which the write is sampled.
- R3: With `conv_inv`=1, data bits go most significant first with line low for 1, and the parity bit is low when the byte has an odd number of ones. The convention is taken when a byte leaves the buffer.
- R4: From 10 ETU after the start edge, the block does not pull the line. It samples the line at exactly 11 ETU after the start edge, and a low level there counts as an error request.
- R5: With no error request, a queued byte starts exactly 12 ETU after the previous start edge.
- R6: After an error request, the same byte is sent again with its start edge exactly 13 ETU after the previous one.
- R7: A byte is repeated at most `retry_limit` times. An error request on the final allowed attempt drops the byte and sets `tx_err`. The next queued byte then starts 13 ETU after the dropped attempt. `tx_err` clears when a write is accepted.
- R8: A write is accepted only while `buf_empty` is 1, and `buf_empty` is 0 from the next clock. A write while `buf_empty` is 0 is ignored and never reaches the line. `buf_empty` returns to 1 one clock after the byte leaves the buffer for the line.
- R9: `empty_irq` is a one-clock pulse in the first clock in which `buf_empty` is 1 again after a byte leaves the buffer.
- R10: A byte written with `wr_last`=1 sets `rx_mode` 12 ETU after the start edge of its successful attempt (13 ETU if it is dropped), provided no byte is queued. While `rx_mode` is 1 the line is not pulled. An accepted write clears `rx_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock; one ETU is `ETU_CLKS` of these |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_inv | input | 1 | Convention from answer-to-reset: 1 for inverse, 0 for direct |
| retry_limit | input | RETRY_W | Maximum number of repeats per byte |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send, in direct convention |
| wr_last | input | 1 | Marks the written byte as the last one before receive |
| io_in | input | 1 | Level seen on the card I/O line |
| io_pull_low | output | 1 | 1 pulls the I/O line low; 0 releases it |
| buf_empty | output | 1 | Holding buffer can accept a byte |
| empty_irq | output | 1 | One-clock pulse when the buffer frees up |
| tx_err | output | 1 | Sticky flag: a byte was dropped after the retry cap |
| rx_mode | output | 1 | Line handed over to the receiver after the last byte |

## Verification
A write sampled at a rising edge shows as `buf_empty` low in the next clock. From an idle block, the start bit appears one clock after that. `buf_empty` and `empty_irq` change one clock after the byte leaves the buffer. The start edge of the next byte, and `rx_mode`, are due exactly 12 or 13 ETU after the previous start edge, counted in clocks. The bench reference model advances once per rising edge. The bench compares every output against it at the falling edge, so each result is looked at in the cycle it is due. Spacing, retries and turnaround are also measured directly from observed start edges as clock distances.

// File: rtl/t0tx_pkg.sv
package t0tx_pkg;
   // character geometry in ETU slots, counted from the start edge
   localparam int unsigned CHAR_W      = 8;
   localparam int unsigned FRAME_W     = CHAR_W + 2;   // start + data + parity
   localparam int unsigned SAMPLE_SLOT = FRAME_W + 1;  // guard-time sample slot
   localparam int unsigned GAP_OK      = FRAME_W + 2;  // start-to-start, accepted
   localparam int unsigned GAP_NAK     = FRAME_W + 3;  // start-to-start, refused
   localparam int unsigned SLOT_W      = 4;
   localparam int unsigned EXT_W       = 1 << SLOT_W;

   typedef logic [CHAR_W-1:0]  byte_t;
   typedef logic [FRAME_W-1:0] frame_t;
   typedef logic [SLOT_W-1:0]  slot_t;
endpackage

// File: rtl/t0tx_etu_timer.sv
module t0tx_etu_timer
   import t0tx_pkg::*;
#(
   parameter int unsigned ETU_CLKS = 372
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  restart,
   input  logic  run,
   output slot_t slot,
   output logic  slot_first,
   output logic  slot_last
);
   localparam int unsigned CNT_W = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(ETU_CLKS - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         slot <= '0;
      end else if (restart) begin
         cnt  <= '0;
         slot <= '0;
      end else if (run) begin
         if (cnt == CNT_TOP) begin
            cnt  <= '0;
            slot <= slot + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign slot_first = (cnt == '0);
   assign slot_last  = (cnt == CNT_TOP);
endmodule

// File: rtl/t0tx_frame_enc.sv
module t0tx_frame_enc
   import t0tx_pkg::*;
#(
   parameter bit SUPPORT_INVERSE = 1'b1
) (
   input  byte_t  data,
   input  logic   inverse,
   output frame_t line
);
   logic odd;
   assign odd     = ^data;
   assign line[0] = 1'b0;

   generate
      if (SUPPORT_INVERSE) begin : g_both
         for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_bit
            assign line[1+gi] = inverse ? ~data[CHAR_W-1-gi] : data[gi];
         end
         assign line[FRAME_W-1] = inverse ? ~odd : odd;
      end else begin : g_direct
         logic unused_inverse;
         assign unused_inverse = inverse;
         for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_bit
            assign line[1+gi] = data[gi];
         end
         assign line[FRAME_W-1] = odd;
      end
   endgenerate
endmodule

// File: rtl/t0tx_ctrl.sv
module t0tx_ctrl
   import t0tx_pkg::*;
#(
   parameter int unsigned RETRY_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  byte_t              wr_data,
   input  logic               wr_last,
   input  logic [RETRY_W-1:0] retry_limit,
   input  logic               io_in,
   input  slot_t              slot,
   input  logic               slot_first,
   input  logic               slot_last,
   input  frame_t             enc_line,
   output byte_t              hold_data,
   output logic               tmr_restart,
   output logic               tmr_run,
   output logic               io_pull_low,
   output logic               buf_empty,
   output logic               empty_irq,
   output logic               tx_err,
   output logic               rx_mode,
   output logic [RETRY_W-1:0] retries
);
   logic   hold_v, hold_last, sending, cur_last, refused;
   frame_t frame;
   logic [EXT_W-1:0] frame_ext;

   logic at_sample, end_ok, end_nak, can_retry, do_retry, give_up, retire, take;

   assign at_sample = sending && (slot == slot_t'(SAMPLE_SLOT)) && slot_first;
   assign end_ok    = sending && !refused && (slot == slot_t'(GAP_OK - 1))  && slot_last;
   assign end_nak   = sending &&  refused && (slot == slot_t'(GAP_NAK - 1)) && slot_last;
   assign can_retry = (retries < retry_limit);
   assign do_retry  = end_nak && can_retry;
   assign give_up   = end_nak && !can_retry;
   assign retire    = end_ok || give_up;
   assign take      = hold_v && (!sending || retire);

   assign tmr_restart = take || do_retry;
   assign tmr_run     = sending;

   assign frame_ext   = {{(EXT_W - FRAME_W){1'b1}}, frame};
   assign io_pull_low = sending && !frame_ext[slot];
   assign buf_empty   = !hold_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v    <= 1'b0;
         hold_data <= '0;
         hold_last <= 1'b0;
         sending   <= 1'b0;
         frame     <= '1;
         cur_last  <= 1'b0;
         refused   <= 1'b0;
         retries   <= '0;
         empty_irq <= 1'b0;
         tx_err    <= 1'b0;
         rx_mode   <= 1'b0;
      end else begin
         empty_irq <= take;
         if (take) begin
            hold_v   <= 1'b0;
            frame    <= enc_line;
            cur_last <= hold_last;
            retries  <= '0;
            refused  <= 1'b0;
            sending  <= 1'b1;
         end else if (do_retry) begin
            retries <= retries + 1'b1;
            refused <= 1'b0;
         end else if (retire) begin
            sending <= 1'b0;
            retries <= '0;
         end
         if (at_sample)
            refused <= ~io_in;
         if (retire && cur_last && !hold_v)
            rx_mode <= 1'b1;
         if (give_up)
            tx_err <= 1'b1;
         if (wr_en && !hold_v) begin
            hold_v    <= 1'b1;
            hold_data <= wr_data;
            hold_last <= wr_last;
            rx_mode   <= 1'b0;
            tx_err    <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/t0_char_tx.sv
module t0_char_tx
   import t0tx_pkg::*;
#(
   parameter int unsigned ETU_CLKS        = 372,
   parameter int unsigned RETRY_W         = 3,
   parameter bit          SUPPORT_INVERSE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               conv_inv,
   input  logic [RETRY_W-1:0] retry_limit,
   input  logic               wr_en,
   input  logic [7:0]         wr_data,
   input  logic               wr_last,
   input  logic               io_in,
   output logic               io_pull_low,
   output logic               buf_empty,
   output logic               empty_irq,
   output logic               tx_err,
   output logic               rx_mode
);
   generate
      if (ETU_CLKS < 4) begin : g_chk_etu
         $error("ETU_CLKS must be at least 4");
      end
      if (RETRY_W < 1 || RETRY_W > 8) begin : g_chk_retry
         $error("RETRY_W must be between 1 and 8");
      end
      if ($clog2(GAP_NAK + 1) > SLOT_W) begin : g_chk_slot
         $error("SLOT_W too narrow for the character spacing");
      end
   endgenerate

   slot_t              w_slot;
   logic               w_slot_first, w_slot_last, w_restart, w_run;
   byte_t              w_hold_data;
   frame_t             w_enc;
   logic [RETRY_W-1:0] w_retries;

   t0tx_etu_timer #(.ETU_CLKS(ETU_CLKS)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (w_restart),
      .run        (w_run),
      .slot       (w_slot),
      .slot_first (w_slot_first),
      .slot_last  (w_slot_last)
   );

   t0tx_frame_enc #(.SUPPORT_INVERSE(SUPPORT_INVERSE)) u_enc (
      .data    (w_hold_data),
      .inverse (conv_inv),
      .line    (w_enc)
   );

   t0tx_ctrl #(.RETRY_W(RETRY_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .wr_last     (wr_last),
      .retry_limit (retry_limit),
      .io_in       (io_in),
      .slot        (w_slot),
      .slot_first  (w_slot_first),
      .slot_last   (w_slot_last),
      .enc_line    (w_enc),
      .hold_data   (w_hold_data),
      .tmr_restart (w_restart),
      .tmr_run     (w_run),
      .io_pull_low (io_pull_low),
      .buf_empty   (buf_empty),
      .empty_irq   (empty_irq),
      .tx_err      (tx_err),
      .rx_mode     (rx_mode),
      .retries     (w_retries)
   );
endmodule

// File: rtl/t0tx_checker.sv
module t0tx_checker
   import t0tx_pkg::*;
#(
   parameter int unsigned RETRY_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [RETRY_W-1:0] retry_limit,
   input logic               io_pull_low,
   input logic               buf_empty,
   input logic               empty_irq,
   input logic               tx_err,
   input logic               rx_mode,
   input slot_t              slot,
   input logic               slot_first,
   input logic [RETRY_W-1:0] retries
);
   AST_EDGE_ON_ETU: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(io_pull_low) |-> slot_first); // R2

   AST_GUARD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (slot >= slot_t'(FRAME_W)) |-> !io_pull_low); // R4

   AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      retries <= retry_limit); // R7

   AST_WRITE_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && buf_empty) |=> !tx_err); // R7

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && buf_empty) |=> !buf_empty); // R8

   AST_IRQ_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      empty_irq |-> (buf_empty && $past(!buf_empty))); // R9

   AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rx_mode |-> !io_pull_low); // R10

   AST_WRITE_ENDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && buf_empty) |=> !rx_mode); // R10
endmodule

bind t0_char_tx t0tx_checker #(.RETRY_W(RETRY_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .retry_limit (retry_limit),
   .io_pull_low (io_pull_low),
   .buf_empty   (buf_empty),
   .empty_irq   (empty_irq),
   .tx_err      (tx_err),
   .rx_mode     (rx_mode),
   .slot        (w_slot),
   .slot_first  (w_slot_first),
   .retries     (w_retries)
);

// File: tb/t0_char_tx_test.sv
module t0_char_tx_test;
   localparam int CLK_PERIOD = 10;
   localparam int E          = 16;
   localparam int RW         = 3;
   localparam int WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_inv = 1'b0;
   logic [RW-1:0] retry_limit = 3'd2;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_data = 8'h00;
   logic          wr_last = 1'b0;
   logic          card_pull = 1'b0;
   logic          io_pull_low, buf_empty, empty_irq, tx_err, rx_mode;
   wire           io_in = !(io_pull_low || card_pull);

   always #(CLK_PERIOD/2) clk = ~clk;

   t0_char_tx #(.ETU_CLKS(E), .RETRY_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .conv_inv(conv_inv), .retry_limit(retry_limit),
      .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .io_in(io_in),
      .io_pull_low(io_pull_low), .buf_empty(buf_empty), .empty_irq(empty_irq),
      .tx_err(tx_err), .rx_mode(rx_mode)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   function automatic logic [9:0] code_char(input logic [7:0] d, input logic inv);
      logic [9:0] f;
      int ones;
      ones = $countones(d);
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) f[1+i] = inv ? !d[7-i] : d[i];
      f[9] = inv ? (ones % 2 == 0) : (ones % 2 == 1);
      return f;
   endfunction

   bit         m_hold_v, m_hl, m_active, m_last, m_seen, m_naknow, m_irq, m_txerr, m_rx;
   logic [7:0] m_hd;
   logic [9:0] m_frame;
   int         m_t, m_tries, nak_left;
   bit         old_hold, fin, again;

   task automatic pick_nak();
      m_naknow = (nak_left > 0);
      if (nak_left > 0) nak_left--;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_hold_v = 0; m_active = 0; m_t = 0; m_irq = 0; m_txerr = 0; m_rx = 0;
         m_seen = 0; m_naknow = 0; m_tries = 0; m_last = 0; m_frame = '1;
      end else begin
         old_hold = m_hold_v; m_irq = 0; fin = 0; again = 0;
         if (m_active) begin
            if (m_t == 11*E) m_seen = card_pull;
            if (!m_seen && m_t == 12*E-1) fin = 1;
            else if (m_seen && m_t == 13*E-1) begin
               if (m_tries < int'(retry_limit)) begin m_tries++; again = 1; end
               else begin m_txerr = 1; fin = 1; end
            end
         end
         if (fin) begin
            m_active = 0;
            if (m_last && !old_hold) m_rx = 1;
         end
         if (again) begin
            m_t = 0; m_seen = 0; pick_nak();
         end else if (!m_active && old_hold) begin
            m_active = 1; m_t = 0; m_seen = 0; m_tries = 0; m_hold_v = 0; m_irq = 1;
            m_frame = code_char(m_hd, conv_inv); m_last = m_hl; pick_nak();
         end else if (m_active) begin
            m_t++;
         end
         if (wr_en && !old_hold) begin
            m_hold_v = 1; m_hd = wr_data; m_hl = wr_last; m_txerr = 0; m_rx = 0;
         end
      end
   end

   // ---------------- per-clock comparison and observation ----------------
   int cyc = 0;
   int last_start = -100000;
   int starts[$];
   int rx_rise = -1;
   bit prev_pull = 0, prev_rx = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         chk(m_t >= 10*E ? "R4" : (conv_inv ? "R3" : "R2"), "io_pull_low", int'(io_pull_low),
             int'(m_active && m_t < 10*E && !m_frame[m_t/E]));
         chk("R8", "buf_empty", int'(buf_empty), int'(!m_hold_v));
         chk("R9", "empty_irq", int'(empty_irq), int'(m_irq));
         chk("R7", "tx_err", int'(tx_err), int'(m_txerr));
         chk("R10", "rx_mode", int'(rx_mode), int'(m_rx));
         if (io_pull_low && !prev_pull && (cyc - last_start >= 10*E)) begin
            starts.push_back(cyc);
            last_start = cyc;
         end
         if (rx_mode && !prev_rx) rx_rise = cyc;
      end
      prev_pull = io_pull_low;
      prev_rx   = rx_mode;
      card_pull = m_active && m_naknow && (m_t >= 10*E + E/2) && (m_t < 11*E + E/2);
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [7:0] d, input logic last);
      while (!buf_empty) @(negedge clk);
      wr_data = d; wr_last = last; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_last = 1'b0;
   endtask

   task automatic wait_idle();
      int q = 0;
      while (q < 3*E) begin
         @(negedge clk);
         if (buf_empty && !m_active) q++; else q = 0;
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset io_pull_low", int'(io_pull_low), 0);
      chk("R1", "reset buf_empty", int'(buf_empty), 1);
      chk("R1", "reset empty_irq", int'(empty_irq), 0);
      chk("R1", "reset tx_err", int'(tx_err), 0);
      chk("R1", "reset rx_mode", int'(rx_mode), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R5: direct convention, back to back
      starts.delete();
      send(8'h3B, 1'b0);
      send(8'hA5, 1'b0);
      wait_idle();
      chk("R5", "start count", starts.size(), 2);
      if (starts.size() == 2) chk("R5", "start spacing", starts[1] - starts[0], 12*E);

      // R6: one refusal, repeated once
      starts.delete();
      nak_left = 1;
      send(8'h5C, 1'b0);
      wait_idle();
      chk("R6", "attempts", starts.size(), 2);
      if (starts.size() == 2) chk("R6", "repeat spacing", starts[1] - starts[0], 13*E);
      chk("R6", "tx_err after recovered repeat", int'(tx_err), 0);

      // R8: write while buffer full is ignored
      starts.delete();
      send(8'h11, 1'b0);
      send(8'h22, 1'b0);
      wr_data = 8'hEE; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      wait_idle();
      chk("R8", "characters sent after ignored write", starts.size(), 2);

      // R7: cap of one repeat exceeded, next byte at 13 ETU
      retry_limit = 3'd1;
      starts.delete();
      nak_left = 2;
      send(8'h81, 1'b0);
      send(8'h42, 1'b0);
      wait_idle();
      chk("R7", "attempts incl. next byte", starts.size(), 3);
      if (starts.size() == 3) chk("R7", "spacing after drop", starts[2] - starts[1], 13*E);
      chk("R7", "tx_err set", int'(tx_err), 1);

      // R7: zero repeats allowed, then cleared by a write
      retry_limit = 3'd0;
      starts.delete();
      nak_left = 1;
      send(8'h77, 1'b0);
      wait_idle();
      chk("R7", "no repeat at limit 0", starts.size(), 1);
      chk("R7", "tx_err at limit 0", int'(tx_err), 1);
      send(8'h10, 1'b0);
      chk("R7", "tx_err cleared by write", int'(tx_err), 0);
      wait_idle();

      // R3 / R10: inverse convention, last byte turns the line around
      retry_limit = 3'd2;
      conv_inv = 1'b1;
      starts.delete();
      rx_rise = -1;
      send(8'h3F, 1'b0);
      send(8'h00, 1'b0);
      send(8'hFF, 1'b1);
      wait_idle();
      chk("R10", "rx_mode after last", int'(rx_mode), 1);
      if (starts.size() == 3) chk("R10", "turnaround delay", rx_rise - starts[2], 12*E);
      else chk("R3", "inverse start count", starts.size(), 3);
      send(8'hC3, 1'b0);
      chk("R10", "rx_mode cleared by write", int'(rx_mode), 0);
      wait_idle();

      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion earlier", WATCHDOG);
      summary();
      $finish;
   end
endmodule